// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Controller

This block chooses the oscillator that clocks the core after a reset or a wake-up from sleep. When the enable configuration bit is set and the primary source is a crystal, the core starts at once on the internal RC clock. Meanwhile a start-up counter in the primary clock domain counts primary cycles. When the count expires, the core is moved to the primary clock through a glitch-free gate pair.

If the enable bit is clear, the core gets no clock until the count expires. In external-clock mode there is no start-up delay, and the core goes straight to the primary clock. Software may request sleep, or hold the core on the internal clock through the clock-select bits, before the count expires. Sleep always takes effect first. Every wake-up starts a fresh count.

Top module: `twospeed_clk_ctrl`

## Requirements
- R1: While rst_ni is low, mode_o is 2'b00, pri_active_o is 0 and clk_core_o shows no rising edge.
- R2: After reset with por_i = 1, the block holds mode_o = 2'b00 with no core clock until pwrt_done_i is 1. With por_i = 0 it starts at once.
- R3: In crystal mode (pri_xtal_i = 1) with two_speed_en_i = 1, the start phase reports mode_o = 2'b01 (internal run) and the core runs at the internal clock rate with pri_active_o = 0.
- R4: In crystal mode with two_speed_en_i = 0, the start phase reports mode_o = 2'b00 and clk_core_o is held still until the count expires.
- R5: In external-clock mode (pri_xtal_i = 0), the core moves to the primary clock within a few cycles, with no start-up count: mode_o = 2'b10 and pri_active_o = 1.
- R6: In crystal mode, the move to the primary clock happens no earlier than OST_CYCLES primary cycles after the start phase begins, and it follows shortly after.
- R7: pri_active_o is 1 only while mode_o = 2'b10 and the primary clock drives clk_core_o.
- R8: A one-cycle sleep_req_i pulse during internal run or primary run gives mode_o = 2'b11, pri_active_o = 0 and no core clock. A one-cycle wake_i pulse (taken even if it arrives early) restarts the start phase with a fresh full count.
- R9: When clk_sel_i is not 2'b00, the core runs on the internal clock (mode_o = 2'b01), even after the count has expired and whatever two_speed_en_i is. Returning clk_sel_i to 2'b00 moves the core to the primary clock.
- R10: clk_core_o never shows a pulse shorter than half the faster source period, and the two clock gates are never open at once.
- R11: If a sleep request and the expiry of the count fall in the same cycle, sleep wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int_i | input | 1 | Internal RC clock, also clocks the control logic |
| clk_pri_i | input | 1 | Raw primary oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| por_i | input | 1 | Marks the current reset as a power-on reset |
| pwrt_done_i | input | 1 | Power-up timer has timed out |
| wake_i | input | 1 | Wake event from sleep |
| sleep_req_i | input | 1 | Software sleep request |
| two_speed_en_i | input | 1 | Two-speed start-up enable configuration bit |
| pri_xtal_i | input | 1 | Primary mode: 1 crystal, 0 external clock |
| clk_sel_i | input | 2 | Software clock select; 2'b00 follows the primary |
| clk_core_o | output | 1 | Gated core clock |
| pri_active_o | output | 1 | Primary oscillator is clocking the core |
| mode_o | output | 2 | 00 hold, 01 internal run, 10 primary run, 11 sleep |

## Verification
The critical coincidence is the expiry of the start-up count landing in the same control cycle as a software sleep request. The bench provokes it by sweeping the arrival time of a one-cycle sleep pulse across the window in which the switch to the primary clock is expected, in steps finer than one internal period. In every case the block must end in sleep with pri_active_o at 0 and no core edges, and no narrowed clock pulse may appear during the overlapping handover.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [2:0] {
    ST_BOOT, ST_HOLD, ST_INT, ST_PRI, ST_SLEEP
  } tsc_state_e;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_INT   = 2'b01,
    MODE_PRI   = 2'b10,
    MODE_SLEEP = 2'b11
  } tsc_mode_e;

  localparam logic [1:0] SEL_PRIMARY = 2'b00;
endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/tsc_ost_counter.sv
module tsc_ost_counter #(
  parameter int OST_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_pri_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(OST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(OST_CYCLES);

  logic run_s;
  logic [CW-1:0] cnt_q;

  tsc_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk_i(clk_pri_i), .rst_ni(rst_ni), .d_i(run_i), .q_o(run_s)
  );

  always_ff @(posedge clk_pri_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_s)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);

  AST_CNT_MONO: assert property (@(posedge clk_pri_i) disable iff (!rst_ni)
    (run_s && $past(run_s)) |-> (cnt_q >= $past(cnt_q))); // R6
endmodule

// File: rtl/tsc_clk_switch.sv
module tsc_clk_switch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_int_i,
  input  logic clk_pri_i,
  input  logic rst_ni,
  input  logic want_int_i,
  input  logic want_pri_i,
  output logic clk_core_o,
  output logic pri_on_o
);
  logic pri_gate_si, want_pri_sp, int_gate_sp;
  logic int_arm_q, int_gate_q, pri_arm_q, pri_gate_q;

  tsc_sync #(.STAGES(SYNC_STAGES)) u_pri_on_sync (
    .clk_i(clk_int_i), .rst_ni(rst_ni), .d_i(pri_gate_q), .q_o(pri_gate_si)
  );
  tsc_sync #(.STAGES(SYNC_STAGES)) u_want_pri_sync (
    .clk_i(clk_pri_i), .rst_ni(rst_ni), .d_i(want_pri_i), .q_o(want_pri_sp)
  );
  tsc_sync #(.STAGES(SYNC_STAGES)) u_int_on_sync (
    .clk_i(clk_pri_i), .rst_ni(rst_ni), .d_i(int_gate_q), .q_o(int_gate_sp)
  );

  // internal side: open only after primary gate is confirmed closed
  always_ff @(posedge clk_int_i or negedge rst_ni) begin
    if (!rst_ni) int_arm_q <= 1'b0;
    else         int_arm_q <= want_int_i & ~pri_gate_si;
  end
  always_ff @(negedge clk_int_i or negedge rst_ni) begin
    if (!rst_ni) int_gate_q <= 1'b0;
    else         int_gate_q <= int_arm_q;
  end

  // primary side: open only after internal gate is confirmed closed
  always_ff @(posedge clk_pri_i or negedge rst_ni) begin
    if (!rst_ni) pri_arm_q <= 1'b0;
    else         pri_arm_q <= want_pri_sp & ~int_gate_sp;
  end
  always_ff @(negedge clk_pri_i or negedge rst_ni) begin
    if (!rst_ni) pri_gate_q <= 1'b0;
    else         pri_gate_q <= pri_arm_q;
  end

  assign clk_core_o = (clk_int_i & int_gate_q) | (clk_pri_i & pri_gate_q);
  assign pri_on_o   = pri_gate_si;

  AST_GATES_EXCL: assert property (@(posedge clk_int_i) disable iff (!rst_ni)
    !(int_gate_q && pri_gate_q)); // R10
  AST_SLEEP_GATED: assert property (@(posedge clk_int_i) disable iff (!rst_ni)
    (!want_int_i && $past(!want_int_i) && $past(!want_int_i, 2)) |-> !int_gate_q); // R8
endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
(
  input  logic       clk_int_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       pwrt_done_i,
  input  logic       wake_i,
  input  logic       sleep_req_i,
  input  logic       two_speed_en_i,
  input  logic       pri_xtal_i,
  input  logic [1:0] clk_sel_i,
  input  logic       ost_done_i,
  input  logic       pri_on_i,
  output logic       want_int_o,
  output logic       want_pri_o,
  output logic       cnt_run_o,
  output logic [1:0] mode_o,
  output logic       pri_active_o
);
  tsc_state_e state_q, state_d, start_st;
  logic wake_pend_q, ready, sel_pri;

  assign ready    = pri_xtal_i ? ost_done_i : 1'b1;
  assign sel_pri  = (clk_sel_i == SEL_PRIMARY);
  assign start_st = !pri_xtal_i    ? ST_PRI :
                    two_speed_en_i ? ST_INT : ST_HOLD;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_BOOT:  if (!por_i || pwrt_done_i) state_d = start_st;
      ST_HOLD:  if (ready) state_d = ST_PRI;
      ST_INT: begin
        if (sleep_req_i)          state_d = ST_SLEEP;
        else if (ready && sel_pri) state_d = ST_PRI;
      end
      ST_PRI: begin
        if (sleep_req_i)   state_d = ST_SLEEP;
        else if (!sel_pri) state_d = ST_INT;
      end
      // wait for the counter to be seen cleared before restarting
      ST_SLEEP: if ((wake_i || wake_pend_q) && !ost_done_i) state_d = start_st;
      default:  state_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk_int_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_BOOT;
      wake_pend_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      wake_pend_q <= (state_q == ST_SLEEP) && (state_d == ST_SLEEP) &&
                     (wake_pend_q || wake_i);
    end
  end

  assign want_int_o = (state_q == ST_INT);
  assign want_pri_o = (state_q == ST_PRI);
  assign cnt_run_o  = (state_q == ST_HOLD) || (state_q == ST_INT) || (state_q == ST_PRI);

  always_comb begin
    unique case (state_q)
      ST_INT:   mode_o = MODE_INT;
      ST_PRI:   mode_o = MODE_PRI;
      ST_SLEEP: mode_o = MODE_SLEEP;
      default:  mode_o = MODE_HOLD;
    endcase
  end

  assign pri_active_o = (state_q == ST_PRI) && pri_on_i;

  AST_BOOT_WAIT: assert property (@(posedge clk_int_i) disable iff (!rst_ni)
    (state_q == ST_BOOT && por_i && !pwrt_done_i) |=> (state_q == ST_BOOT)); // R2
  AST_SLEEP_WINS: assert property (@(posedge clk_int_i) disable iff (!rst_ni)
    (sleep_req_i && (state_q == ST_INT || state_q == ST_PRI)) |=> (state_q == ST_SLEEP)); // R11
  AST_PRI_AFTER_OST: assert property (@(posedge clk_int_i) disable iff (!rst_ni)
    (pri_xtal_i && state_q == ST_PRI && ($past(state_q) == ST_INT || $past(state_q) == ST_HOLD))
    |-> $past(ost_done_i)); // R6
endmodule

// File: rtl/twospeed_clk_ctrl.sv
module twospeed_clk_ctrl
  import tsc_pkg::*;
#(
  parameter int OST_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_int_i,
  input  logic       clk_pri_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       pwrt_done_i,
  input  logic       wake_i,
  input  logic       sleep_req_i,
  input  logic       two_speed_en_i,
  input  logic       pri_xtal_i,
  input  logic [1:0] clk_sel_i,
  output logic       clk_core_o,
  output logic       pri_active_o,
  output logic [1:0] mode_o
);
  logic ost_done_p, ost_done_s, cnt_run, want_int, want_pri, pri_on;

  tsc_ctrl u_ctrl (
    .clk_int_i      (clk_int_i),
    .rst_ni         (rst_ni),
    .por_i          (por_i),
    .pwrt_done_i    (pwrt_done_i),
    .wake_i         (wake_i),
    .sleep_req_i    (sleep_req_i),
    .two_speed_en_i (two_speed_en_i),
    .pri_xtal_i     (pri_xtal_i),
    .clk_sel_i      (clk_sel_i),
    .ost_done_i     (ost_done_s),
    .pri_on_i       (pri_on),
    .want_int_o     (want_int),
    .want_pri_o     (want_pri),
    .cnt_run_o      (cnt_run),
    .mode_o         (mode_o),
    .pri_active_o   (pri_active_o)
  );

  tsc_ost_counter #(.OST_CYCLES(OST_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ost (
    .clk_pri_i (clk_pri_i),
    .rst_ni    (rst_ni),
    .run_i     (cnt_run),
    .done_o    (ost_done_p)
  );

  tsc_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk_i(clk_int_i), .rst_ni(rst_ni), .d_i(ost_done_p), .q_o(ost_done_s)
  );

  tsc_clk_switch #(.SYNC_STAGES(SYNC_STAGES)) u_switch (
    .clk_int_i  (clk_int_i),
    .clk_pri_i  (clk_pri_i),
    .rst_ni     (rst_ni),
    .want_int_i (want_int),
    .want_pri_i (want_pri),
    .clk_core_o (clk_core_o),
    .pri_on_o   (pri_on)
  );

  AST_ACTIVE_PRI: assert property (@(posedge clk_int_i) disable iff (!rst_ni)
    pri_active_o |-> (mode_o == MODE_PRI && u_switch.pri_gate_q)); // R7
endmodule

// File: tb/twospeed_clk_ctrl_tb.sv
`timescale 1ns/1ps
module twospeed_clk_ctrl_tb_top;
  logic clk_int = 1'b0, clk_pri = 1'b0, rst_ni = 1'b0;
  logic por = 1'b0, pwrt_done = 1'b0, wake = 1'b0, sleep_req = 1'b0;
  logic en = 1'b0, xtal = 1'b1;
  logic [1:0] sel = 2'b00;
  logic clk_core, pri_active;
  logic [1:0] mode;

  int n_checks = 0, n_fail = 0, edge_cnt = 0, glitch_cnt = 0;
  bit mon_en = 1'b0;
  realtime last_edge = 0.0, t0 = 0.0;

  always #4 clk_int = ~clk_int;   // 125 MHz internal
  always #3 clk_pri = ~clk_pri;   // primary

  twospeed_clk_ctrl dut_i (
    .clk_int_i(clk_int), .clk_pri_i(clk_pri), .rst_ni(rst_ni), .por_i(por),
    .pwrt_done_i(pwrt_done), .wake_i(wake), .sleep_req_i(sleep_req),
    .two_speed_en_i(en), .pri_xtal_i(xtal), .clk_sel_i(sel),
    .clk_core_o(clk_core), .pri_active_o(pri_active), .mode_o(mode)
  );

  always @(posedge clk_core) edge_cnt = edge_cnt + 1;

  always @(clk_core) begin
    if (mon_en && rst_ni && ($realtime - last_edge) < 2.9) glitch_cnt = glitch_cnt + 1;
    last_edge = $realtime;
  end

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    n_checks++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic edges(int ns, output int n);
    int a;
    a = edge_cnt;
    #(ns);
    n = edge_cnt - a;
  endtask

  task automatic wait_until(realtime t);
    if ($realtime < t) #(t - $realtime);
    @(negedge clk_int);
  endtask

  task automatic pulse_sleep();
    @(negedge clk_int) sleep_req = 1'b1;
    @(negedge clk_int) sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk_int) wake = 1'b1;
    @(negedge clk_int) wake = 1'b0;
    t0 = $realtime;
  endtask

  task automatic apply_reset(bit p, bit e, bit x);
    int n;
    @(negedge clk_int);
    mon_en = 1'b0;
    rst_ni = 1'b0;
    por = p; en = e; xtal = x; pwrt_done = 1'b0;
    sleep_req = 1'b0; wake = 1'b0; sel = 2'b00;
    #20;
    edges(40, n);
    chk("R1 no core clock in reset", n, 0);
    chk("R1 mode in reset", int'(mode), 0);
    chk("R1 status in reset", int'(pri_active), 0);
    @(negedge clk_int) rst_ni = 1'b1;
    mon_en = 1'b1;
    t0 = $realtime;
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int n;
    // R2..R7: sweep of all reset configurations
    for (int c = 0; c < 8; c++) begin
      apply_reset(c[2], c[1], c[0]);
      if (c[2]) begin
        #100; @(negedge clk_int);
        chk("R2 waits for power-up timer mode", int'(mode), 0);
        edges(80, n);
        chk("R2 no core clock before power-up timer", n, 0);
        @(negedge clk_int) pwrt_done = 1'b1;
        t0 = $realtime;
      end
      #100; @(negedge clk_int);
      if (!c[0]) begin
        chk("R5 external clock mode", int'(mode), 2);
        chk("R5 external clock status", int'(pri_active), 1);
        edges(60, n);
        chk_rng("R5 primary rate", n, 9, 11);
      end else if (c[1]) begin
        chk("R3 internal run mode", int'(mode), 1);
        chk("R3 status low", int'(pri_active), 0);
        edges(80, n);
        chk_rng("R3 internal rate", n, 9, 11);
      end else begin
        chk("R4 hold mode", int'(mode), 0);
        edges(80, n);
        chk("R4 no core clock", n, 0);
      end
      if (c[0]) begin
        wait_until(t0 + 5900.0);
        chk("R6 no early switch status", int'(pri_active), 0);
        chk("R6 no early switch mode", int'(mode), c[1] ? 1 : 0);
        wait_until(t0 + 6700.0);
        chk("R6 switched after count", int'(mode), 2);
        chk("R7 status in primary run", int'(pri_active), 1);
        edges(120, n);
        chk_rng("R7 primary rate", n, 19, 21);
      end
    end

    // R8: sleep before expiry, from primary, and with an early wake
    apply_reset(1'b0, 1'b1, 1'b1);
    #2000;
    pulse_sleep();
    #50; @(negedge clk_int);
    chk("R8 sleep mode from internal", int'(mode), 3);
    chk("R8 sleep status", int'(pri_active), 0);
    edges(100, n);
    chk("R8 no clock in sleep", n, 0);
    pulse_wake();
    #100; @(negedge clk_int);
    chk("R8 wake to internal run", int'(mode), 1);
    wait_until(t0 + 5900.0);
    chk("R8 fresh count after wake", int'(pri_active), 0);
    wait_until(t0 + 6700.0);
    chk("R8 primary after full count", int'(pri_active), 1);
    pulse_sleep();
    #100; @(negedge clk_int);
    chk("R8 sleep mode from primary", int'(mode), 3);
    chk("R8 sleep status from primary", int'(pri_active), 0);
    edges(100, n);
    chk("R8 no clock in sleep from primary", n, 0);
    pulse_wake();
    wait_until(t0 + 5900.0);
    chk("R8 count cleared by sleep", int'(pri_active), 0);
    wait_until(t0 + 6700.0);
    chk("R8 primary again", int'(pri_active), 1);
    pulse_sleep();
    pulse_wake();
    #100; @(negedge clk_int);
    chk("R8 early wake taken", int'(mode), 1);
    wait_until(t0 + 5900.0);
    chk("R8 early wake fresh count", int'(pri_active), 0);
    wait_until(t0 + 6700.0);
    chk("R8 early wake reaches primary", int'(pri_active), 1);

    // R9: clock select keeps the internal clock
    apply_reset(1'b0, 1'b1, 1'b1);
    #200; @(negedge clk_int) sel = 2'b01;
    wait_until(t0 + 6700.0);
    chk("R9 select holds internal mode", int'(mode), 1);
    chk("R9 select holds status low", int'(pri_active), 0);
    edges(80, n);
    chk_rng("R9 internal rate under select", n, 9, 11);
    @(negedge clk_int) sel = 2'b00;
    #200; @(negedge clk_int);
    chk("R9 select back to primary", int'(mode), 2);
    chk("R9 status back", int'(pri_active), 1);
    apply_reset(1'b0, 1'b0, 1'b1);
    wait_until(t0 + 6700.0);
    chk("R9 primary with enable clear", int'(mode), 2);
    @(negedge clk_int) sel = 2'b11;
    #200; @(negedge clk_int);
    chk("R9 select ignores enable", int'(mode), 1);
    chk("R9 status low under select", int'(pri_active), 0);
    edges(80, n);
    chk_rng("R9 internal rate enable clear", n, 9, 11);

    // R11: sleep request swept across the expiry cycle
    for (int k = 0; k < 32; k++) begin
      apply_reset(1'b0, 1'b1, 1'b1);
      #(6100 + 6 * k - 8);
      pulse_sleep();
      #100; @(negedge clk_int);
      chk("R11 sleep wins mode", int'(mode), 3);
      chk("R11 sleep wins status", int'(pri_active), 0);
      edges(100, n);
      chk("R11 no clock after coincident sleep", n, 0);
    end

    chk("R10 no narrow core pulse", glitch_cnt, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule